// File: doc/BRIEF.md
# ADC Output Formatter with Test Words

This block sits between a 10-bit converter result and the output pins. Each rising ADC clock edge captures a new sample into a delay line. A registered output stage presents the sample once the latency for the current operating mode has elapsed. Direct-ADC and auxiliary modes use a short fixed delay. The CCD mode is longer, and longer again when even-odd correction is switched on. The correction arithmetic is not modelled, so in this block it is only extra stages.

An output-select field can replace the data with one of two alternating checkerboard words, or turn the bus off. A select change acts on the next clock edge, and the delay line keeps moving underneath it. A change of latency discards everything in flight. The output then stays at zero until the first sample captured under the new latency reaches the end of the line, so a sample is never shown with the wrong alignment.

Top module: `adc_out_fmt`

## Requirements
- R1: While `rst_ni` is low, `data_o` is 0 and `data_oe_o` is 0.
- R2: With `out_sel_i` = 2'b00, the sample on `sample_i` at rising edge k appears on `data_o` just after edge k+L-1, with `data_oe_o` = 1. L is the current latency, and it is 5 in CCD mode with correction off.
- R3: With `out_sel_i` = 2'b01, the edge drives `data_o` = 0101010101 (D9 down to D0, 10'h155) with `data_oe_o` = 1.
- R4: With `out_sel_i` = 2'b10, the edge drives `data_o` = 1010101010 (10'h2AA) with `data_oe_o` = 1.
- R5: With `out_sel_i` = 2'b11, the edge drives `data_oe_o` = 0 and `data_o` = 0, which means high impedance at the pad.
- R6: When `op_mode_i` is 2'b00 (direct ADC) or 2'b01 (aux), L = 4 whatever the value of `eo_corr_en_i`.
- R7: When `op_mode_i[1]` = 1 (CCD), L = 5 if `eo_corr_en_i` = 0 and L = 7 if `eo_corr_en_i` = 1.
- R8: At an edge where L differs from the L of the previous edge, the delay line is flushed. In pass mode the output reads 0 after that edge and after each following edge until the sample captured at the change edge comes out, L-1 edges later. The same zero fill applies after reset.
- R9: A change of `out_sel_i` takes effect on the next edge and does not stall the delay line. Returning to 2'b00 without a latency change shows the correctly aligned sample on the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ADC clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 10 | Converter result |
| op_mode_i | input | 2 | 00 direct ADC, 01 aux, 1x CCD |
| out_sel_i | input | 2 | 00 data, 01 / 10 checkerboard words, 11 off |
| eo_corr_en_i | input | 1 | Even-odd correction enable (adds delay in CCD mode) |
| data_o | output | 10 | Output word |
| data_oe_o | output | 1 | Output bus enable |

## Verification
The bench steps a free-running random sample stream through every mode and correction combination. Long stretches at one setting show which delay tap is in use. Sparse random setting changes mark the zero-fill window after each flush, and they separate an aux-mode toggle of the correction bit, which must do nothing, from a CCD-mode toggle, which must flush. Random select changes between data, both checkerboard words and the off state show whether the words are exact. They also show whether the delay line keeps running during a pattern, because the first data word after the pattern must already be the aligned sample.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    SEL_DATA  = 2'b00,
    SEL_CHK_A = 2'b01,
    SEL_CHK_B = 2'b10,
    SEL_OFF   = 2'b11
  } out_sel_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/adc_fmt_lat_sel.sv
module adc_fmt_lat_sel #(
  parameter int LAT_SHORT  = 4,
  parameter int LAT_CCD    = 5,
  parameter int LAT_CCD_EO = 7,
  parameter int LW         = 3
) (
  input  logic [1:0]    op_mode_i,
  input  logic          eo_en_i,
  output logic [LW-1:0] lat_o
);
  always_comb begin
    if (op_mode_i[1]) lat_o = eo_en_i ? LW'(LAT_CCD_EO) : LW'(LAT_CCD);
    else              lat_o = LW'(LAT_SHORT);
  end

  always_comb begin
    AST_LAT_LEGAL: assert (lat_o == LW'(LAT_SHORT) || lat_o == LW'(LAT_CCD) ||
                           lat_o == LW'(LAT_CCD_EO)); // R7
  end
endmodule

// File: rtl/adc_fmt_pipe.sv
module adc_fmt_pipe #(
  parameter int DW    = 10,
  parameter int DEPTH = 6,
  parameter int LW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] sample_i,
  input  logic          flush_i,
  input  logic [LW-1:0] lat_i,
  output logic [DW-1:0] tap_o,
  output logic          tap_vld_o
);
  logic [DW-1:0]    dat_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q[0] <= '0;
      vld_q[0] <= 1'b0;
    end else begin
      dat_q[0] <= sample_i;
      vld_q[0] <= 1'b1;
    end
  end

  for (genvar j = 1; j < DEPTH; j++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dat_q[j] <= '0;
        vld_q[j] <= 1'b0;
      end else begin
        dat_q[j] <= dat_q[j-1];
        vld_q[j] <= flush_i ? 1'b0 : vld_q[j-1];
      end
    end
  end

  // the output register adds one stage, so latency L reads stage L-2
  always_comb begin
    tap_o     = '0;
    tap_vld_o = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (lat_i == LW'(j + 2)) begin
        tap_o     = dat_q[j];
        tap_vld_o = vld_q[j];
      end
    end
  end

  AST_VLD_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q & (vld_q + 1'b1)) == '0); // R8
endmodule

// File: rtl/adc_fmt_out_reg.sv
module adc_fmt_out_reg
  import adc_fmt_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] tap_i,
  input  logic          tap_vld_i,
  input  logic          flush_i,
  output logic [DW-1:0] data_o,
  output logic          oe_o
);
  logic [DW-1:0] chk_a;

  for (genvar i = 0; i < DW; i++) begin : g_chk
    assign chk_a[i] = ((i % 2) == 0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      oe_o   <= 1'b0;
    end else begin
      unique case (out_sel_e'(sel_i))
        SEL_DATA: begin
          data_o <= (tap_vld_i && !flush_i) ? tap_i : '0;
          oe_o   <= 1'b1;
        end
        SEL_CHK_A: begin
          data_o <= chk_a;
          oe_o   <= 1'b1;
        end
        SEL_CHK_B: begin
          data_o <= ~chk_a;
          oe_o   <= 1'b1;
        end
        default: begin
          data_o <= '0;
          oe_o   <= 1'b0;
        end
      endcase
    end
  end

  AST_CHK_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 2'b01 |=> oe_o && data_o[0] && !data_o[1] && $countones(data_o) == (DW + 1) / 2); // R3
  AST_CHK_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 2'b10 |=> oe_o && !data_o[0] && data_o[1] && $countones(data_o) == DW / 2); // R4
  AST_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 2'b11 |=> !oe_o && data_o == '0); // R5
  AST_FLUSH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && sel_i == 2'b00 |=> oe_o && data_o == '0); // R8
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
  import adc_fmt_pkg::*;
#(
  parameter int DW         = 10,
  parameter int LAT_SHORT  = 4,
  parameter int LAT_CCD    = 5,
  parameter int LAT_CCD_EO = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] sample_i,
  input  logic [1:0]    op_mode_i,
  input  logic [1:0]    out_sel_i,
  input  logic          eo_corr_en_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  localparam int MAX_LAT = max3(LAT_SHORT, LAT_CCD, LAT_CCD_EO);
  localparam int DEPTH   = MAX_LAT - 1;
  localparam int LW      = $clog2(MAX_LAT + 1);

  logic [LW-1:0] lat_d, lat_q;
  logic          flush;
  logic [DW-1:0] tap;
  logic          tap_vld;

  adc_fmt_lat_sel #(
    .LAT_SHORT(LAT_SHORT), .LAT_CCD(LAT_CCD), .LAT_CCD_EO(LAT_CCD_EO), .LW(LW)
  ) u_lat_sel (
    .op_mode_i(op_mode_i),
    .eo_en_i  (eo_corr_en_i),
    .lat_o    (lat_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= LW'(LAT_CCD);
    else         lat_q <= lat_d;
  end

  assign flush = (lat_d != lat_q);

  adc_fmt_pipe #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_i),
    .flush_i  (flush),
    .lat_i    (lat_d),
    .tap_o    (tap),
    .tap_vld_o(tap_vld)
  );

  adc_fmt_out_reg #(.DW(DW)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (out_sel_i),
    .tap_i    (tap),
    .tap_vld_i(tap_vld),
    .flush_i  (flush),
    .data_o   (data_o),
    .oe_o     (data_oe_o)
  );

  AST_SHORT_NO_EO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_mode_i[1] && !$past(op_mode_i[1]) |-> !flush); // R6
endmodule

// File: tb/adc_out_fmt_bench.sv
module adc_out_fmt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] sample = '0;
  logic [1:0]    op_mode = 2'b10;
  logic [1:0]    out_sel = 2'b00;
  logic          eo_en = 1'b0;
  logic [DW-1:0] data;
  logic          oe;

  int total = 0;
  int bad = 0;
  int n = 0;
  int chg = 0;
  int prev_l = 5;
  logic [1:0] prev_sel = 2'b00;
  logic [DW-1:0] hist [0:4095];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_out_fmt u_adc_out_fmt (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .op_mode_i(op_mode),
    .out_sel_i(out_sel), .eo_corr_en_i(eo_en), .data_o(data), .data_oe_o(oe)
  );

  function automatic int lat_of(input logic [1:0] m, input logic e);
    if (m[1]) return e ? 7 : 5;
    return 4;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] exp_d, input logic exp_oe);
    total++;
    if (data !== exp_d || oe !== exp_oe) begin
      bad++;
      $display("FAIL %s edge=%0d data=%h oe=%b expected data=%h oe=%b",
               req, n, data, oe, exp_d, exp_oe);
    end
  endtask

  // called just after a falling edge; drives, waits one rising edge, checks
  task automatic step(input logic [DW-1:0] s, input logic [1:0] m, input logic e,
                      input logic [1:0] sel);
    int l;
    string tag;
    logic [DW-1:0] exp_d;
    logic exp_oe;
    sample = s; op_mode = m; eo_en = e; out_sel = sel;
    l = lat_of(m, e);
    if (l != prev_l) chg = n;
    prev_l = l;
    hist[n] = s;
    exp_oe = 1'b1;
    case (sel)
      2'b01: begin exp_d = 10'h155; tag = "R3"; end
      2'b10: begin exp_d = 10'h2AA; tag = "R4"; end
      2'b11: begin exp_d = '0; exp_oe = 1'b0; tag = "R5"; end
      default: begin
        if (n - chg >= l - 1) begin
          exp_d = hist[n - l + 1];
          if (prev_sel != 2'b00) tag = "R9";
          else if (l == 4) tag = "R6";
          else if (l == 7) tag = "R7";
          else tag = "R2";
        end else begin
          exp_d = '0;
          tag = "R8";
        end
      end
    endcase
    prev_sel = sel;
    @(posedge clk);
    #1;
    check(tag, exp_d, exp_oe);
    n++;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // directed: every latency setting, fill and steady state
    for (int k = 0; k < 20; k++) step(DW'($urandom), 2'b10, 1'b0, 2'b00);
    for (int k = 0; k < 20; k++) step(DW'($urandom), 2'b10, 1'b1, 2'b00);
    for (int k = 0; k < 20; k++) step(DW'($urandom), 2'b00, 1'b0, 2'b00);
    // R6: toggling correction in aux mode must not flush
    for (int k = 0; k < 20; k++) step(DW'($urandom), 2'b01, k[0], 2'b00);
    for (int k = 0; k < 10; k++) step(10'h3FF, 2'b11, 1'b0, 2'b00);
    step('0, 2'b11, 1'b0, 2'b00);
    for (int k = 0; k < 3; k++) step(DW'($urandom), 2'b11, 1'b0, 2'b01);
    for (int k = 0; k < 3; k++) step(DW'($urandom), 2'b11, 1'b0, 2'b10);
    for (int k = 0; k < 3; k++) step(DW'($urandom), 2'b11, 1'b0, 2'b11);
    for (int k = 0; k < 8; k++) step(DW'($urandom), 2'b11, 1'b0, 2'b00);
    // random phase
    begin
      logic [1:0] m = 2'b10;
      logic e = 1'b0;
      logic [1:0] sel = 2'b00;
      for (int k = 0; k < 2500; k++) begin
        if ($urandom_range(39) == 0) begin m = 2'($urandom); e = 1'($urandom); end
        if ($urandom_range(9) == 0) sel = ($urandom_range(1) == 0) ? 2'b00 : 2'($urandom);
        step(DW'($urandom), m, e, sel);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule